// File: doc/BRIEF.md
# Snoop-Priority Tag Port Arbiter

This block decides, every clock, which of three requesters drives a cache tag array that has a single read/write port. The requesters are the processor load/store pipeline (a lookup), an external coherency snoop (a lookup), and the tag update path that writes tags for line fills and state changes. The tag update path has the highest priority among new requests. An external snoop comes next and always beats the processor. A snoop that arrives in the same cycle as a tag write is accepted but not serviced. Instead it gets a one-cycle retry pulse, and the snoop source must issue it again.

A processor request that loses the port, to a snoop or to a tag write, is not dropped. It goes into a one-entry holding register and is issued on the port in the very next cycle. In that replay cycle the held request outranks everything. All three request ports show not-ready, so a new snoop waits one cycle. It is not retried. This means a steady stream of snoops cannot starve the processor.

All inputs are sampled on the rising clock edge. The tag array command and the retry pulse are registered outputs. A request accepted on one edge therefore drives the tag port during the following cycle.

Top module: `tag_port_arb`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `tag_en` and `snp_retry` are 0, `tag_src` is 0, and `cpu_ready`, `snp_ready` and `wr_ready` are all 1.
- R2: A processor request accepted alone on an edge produces, in the next cycle, `tag_en`=1, `tag_we`=0, `tag_src`=1 (processor), and `tag_idx`/`tag_tid` equal to the request's index and id.
- R3: A snoop accepted alone produces, in the next cycle, `tag_en`=1, `tag_we`=0, `tag_src`=2 (snoop), `tag_idx` equal to the snoop index, and `snp_retry`=0.
- R4: When a processor request and a snoop are accepted on the same edge with no tag write, the next cycle carries the snoop and the cycle after that carries the processor request, with its original index and id.
- R5: In the cycle that follows the acceptance of a processor request that lost the port, `cpu_ready`, `snp_ready` and `wr_ready` are all 0. They return to 1 in the cycle after that.
- R6: A tag write accepted on an edge produces, in the next cycle, `tag_en`=1, `tag_we`=1, `tag_src`=3 (write), with `tag_idx`/`tag_wdata` equal to the write's index and data.
- R7: A snoop accepted on the same edge as a tag write is not looked up. In the next cycle the port carries the write and `snp_retry` is 1 for exactly that one cycle. `snp_retry` is never 1 at any other time.
- R8: A processor request accepted on the same edge as a tag write is replayed on the port in the cycle after the write, with its original index and id.
- R9: When no request is accepted on an edge and no request is held, the next cycle has `tag_en`=0, `tag_we`=0 and `tag_src`=0.
- R10: A snoop that is presented while a processor request is held is stalled by `snp_ready`=0. It is neither looked up nor retried in the replay cycle, and it is serviced after its later acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_valid | input | 1 | Processor lookup request valid |
| cpu_ready | output | 1 | Processor request can be accepted |
| cpu_idx | input | IDX_W | Processor lookup set index |
| cpu_tid | input | TID_W | Processor request id, returned with the lookup |
| snp_valid | input | 1 | Snoop lookup request valid |
| snp_ready | output | 1 | Snoop request can be accepted |
| snp_idx | input | IDX_W | Snoop lookup set index |
| wr_valid | input | 1 | Tag write request valid |
| wr_ready | output | 1 | Tag write can be accepted |
| wr_idx | input | IDX_W | Tag write set index |
| wr_data | input | TAG_W | Tag write data |
| tag_en | output | 1 | Tag port access this cycle |
| tag_we | output | 1 | Tag port access is a write |
| tag_idx | output | IDX_W | Tag port set index |
| tag_wdata | output | TAG_W | Tag port write data |
| tag_src | output | 2 | Owner of the access: 0 none, 1 processor, 2 snoop, 3 write |
| tag_tid | output | TID_W | Processor id for processor lookups, else 0 |
| snp_retry | output | 1 | Snoop rejected, one-cycle pulse |

## Verification
The bench builds the block with IDX_W=7, TAG_W=20 and TID_W=4. Seven index bits cover a 128-set array, and random indices hit the whole range. This shows that a held request keeps its own index rather than picking up the index of the request that displaced it. Four id bits let each replayed lookup carry a distinct id, so a replay that returns the wrong request, or returns it twice, is caught at the ports. The 20-bit write data is wide enough that data taken from the wrong cycle does not match by chance.

// File: rtl/tpa_pkg.sv
package tpa_pkg;

  // Owner of the tag port in a given cycle; encoding is visible on tag_src.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_SNP  = 2'd2,
    SRC_WR   = 2'd3
  } tag_src_e;

  // Result of one arbitration round.
  typedef struct packed {
    tag_src_e src;        // who gets the port next cycle
    logic     from_hold;  // processor access comes from the holding register
    logic     retry;      // accepted snoop is rejected
    logic     capture;    // accepted processor request must be held
  } arb_dec_t;

endpackage

// File: rtl/tpa_pick.sv
module tpa_pick
  import tpa_pkg::*;
(
  input  logic     hold_full,
  input  logic     cpu_fire,
  input  logic     snp_fire,
  input  logic     wr_fire,
  output arb_dec_t dec
);

  // Fixed priority: held replay, tag write, snoop, processor.
  always_comb begin
    dec = '{src: SRC_NONE, from_hold: 1'b0, retry: 1'b0, capture: 1'b0};
    if (hold_full) begin
      dec.src       = SRC_CPU;
      dec.from_hold = 1'b1;
    end else if (wr_fire) begin
      dec.src     = SRC_WR;
      dec.retry   = snp_fire;
      dec.capture = cpu_fire;
    end else if (snp_fire) begin
      dec.src     = SRC_SNP;
      dec.capture = cpu_fire;
    end else if (cpu_fire) begin
      dec.src = SRC_CPU;
    end
  end

endmodule

// File: rtl/tpa_hold.sv
module tpa_hold #(
  parameter int IDX_W = 7,
  parameter int TID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [TID_W-1:0] in_tid,
  output logic             full,
  output logic [IDX_W-1:0] held_idx,
  output logic [TID_W-1:0] held_tid
);

  logic             full_q, full_d;
  logic [IDX_W-1:0] idx_q;
  logic [TID_W-1:0] tid_q;

  // Entry lives exactly one cycle: filled on capture, drained on replay.
  always_comb begin
    full_d = full_q;
    if (capture)     full_d = 1'b1;
    else if (full_q) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      tid_q <= '0;
    end else if (capture) begin
      idx_q <= in_idx;
      tid_q <= in_tid;
    end
  end

  assign full     = full_q;
  assign held_idx = idx_q;
  assign held_tid = tid_q;

endmodule

// File: rtl/tpa_cmd_reg.sv
module tpa_cmd_reg
  import tpa_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int TAG_W = 20,
  parameter int TID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  arb_dec_t         dec,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic [TID_W-1:0] cpu_tid,
  input  logic [IDX_W-1:0] held_idx,
  input  logic [TID_W-1:0] held_tid,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_data,
  output logic             tag_en,
  output logic             tag_we,
  output logic [IDX_W-1:0] tag_idx,
  output logic [TAG_W-1:0] tag_wdata,
  output tag_src_e         tag_src,
  output logic [TID_W-1:0] tag_tid,
  output logic             snp_retry
);

  logic             en_q, en_d;
  logic             we_q, we_d;
  logic             rty_q, rty_d;
  tag_src_e         src_q, src_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [TID_W-1:0] tid_q, tid_d;
  logic [TAG_W-1:0] wd_q;
  logic             idx_ce, wd_ce;

  always_comb begin
    src_d  = dec.src;
    en_d   = (dec.src != SRC_NONE);
    we_d   = (dec.src == SRC_WR);
    rty_d  = dec.retry;
    idx_d  = idx_q;
    tid_d  = '0;
    unique case (dec.src)
      SRC_CPU: begin
        idx_d = dec.from_hold ? held_idx : cpu_idx;
        tid_d = dec.from_hold ? held_tid : cpu_tid;
      end
      SRC_SNP: idx_d = snp_idx;
      SRC_WR:  idx_d = wr_idx;
      default: idx_d = idx_q;
    endcase
  end

  assign idx_ce = (dec.src != SRC_NONE);
  assign wd_ce  = (dec.src == SRC_WR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      we_q  <= 1'b0;
      rty_q <= 1'b0;
      src_q <= SRC_NONE;
      tid_q <= '0;
    end else begin
      en_q  <= en_d;
      we_q  <= we_d;
      rty_q <= rty_d;
      src_q <= src_d;
      tid_q <= tid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_ce) idx_q <= idx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wd_q <= '0;
    else if (wd_ce) wd_q <= wr_data;
  end

  assign tag_en    = en_q;
  assign tag_we    = we_q;
  assign tag_idx   = idx_q;
  assign tag_wdata = wd_q;
  assign tag_src   = src_q;
  assign tag_tid   = tid_q;
  assign snp_retry = rty_q;

endmodule

// File: rtl/tag_port_arb.sv
module tag_port_arb
  import tpa_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int TAG_W = 20,
  parameter int TID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_valid,
  output logic             cpu_ready,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic [TID_W-1:0] cpu_tid,
  input  logic             snp_valid,
  output logic             snp_ready,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_data,
  output logic             tag_en,
  output logic             tag_we,
  output logic [IDX_W-1:0] tag_idx,
  output logic [TAG_W-1:0] tag_wdata,
  output logic [1:0]       tag_src,
  output logic [TID_W-1:0] tag_tid,
  output logic             snp_retry
);

  logic             hold_full;
  logic [IDX_W-1:0] held_idx;
  logic [TID_W-1:0] held_tid;
  logic             accept_ok;
  logic             cpu_fire, snp_fire, wr_fire;
  arb_dec_t         dec;
  tag_src_e         src_out;

  // The replay cycle owns the port, so every port pauses for it.
  assign accept_ok = !hold_full;
  assign cpu_ready = accept_ok;
  assign snp_ready = accept_ok;
  assign wr_ready  = accept_ok;

  assign cpu_fire = cpu_valid && accept_ok;
  assign snp_fire = snp_valid && accept_ok;
  assign wr_fire  = wr_valid  && accept_ok;

  tpa_pick u_pick (
    .hold_full (hold_full),
    .cpu_fire  (cpu_fire),
    .snp_fire  (snp_fire),
    .wr_fire   (wr_fire),
    .dec       (dec)
  );

  tpa_hold #(.IDX_W(IDX_W), .TID_W(TID_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (dec.capture),
    .in_idx   (cpu_idx),
    .in_tid   (cpu_tid),
    .full     (hold_full),
    .held_idx (held_idx),
    .held_tid (held_tid)
  );

  tpa_cmd_reg #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TID_W(TID_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec       (dec),
    .cpu_idx   (cpu_idx),
    .cpu_tid   (cpu_tid),
    .held_idx  (held_idx),
    .held_tid  (held_tid),
    .snp_idx   (snp_idx),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .tag_en    (tag_en),
    .tag_we    (tag_we),
    .tag_idx   (tag_idx),
    .tag_wdata (tag_wdata),
    .tag_src   (src_out),
    .tag_tid   (tag_tid),
    .snp_retry (snp_retry)
  );

  assign tag_src = src_out;

endmodule

// File: rtl/tag_port_arb_chk.sv
module tag_port_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_valid,
  input logic       cpu_ready,
  input logic       snp_valid,
  input logic       snp_ready,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       tag_en,
  input logic       tag_we,
  input logic [1:0] tag_src,
  input logic       snp_retry
);

  logic cpu_acc, snp_acc, wr_acc;
  assign cpu_acc = cpu_valid && cpu_ready;
  assign snp_acc = snp_valid && snp_ready;
  assign wr_acc  = wr_valid  && wr_ready;

  // R2: lone processor request is looked up next cycle
  p_cpu_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_acc && !snp_acc && !wr_acc) |=> (tag_en && !tag_we && tag_src == 2'd1));

  // R3: lone snoop is looked up next cycle without retry
  p_snp_alone_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_acc && !wr_acc) |=> (tag_src == 2'd2 && !snp_retry));

  // R4: snoop first, then the displaced processor request
  p_snoop_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_acc && cpu_acc && !wr_acc) |=> (tag_src == 2'd2) ##1 (tag_src == 2'd1));

  // R5: all ports pause in the replay cycle
  p_ready_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_acc && (snp_acc || wr_acc)) |=> (!cpu_ready && !snp_ready && !wr_ready));

  // R6: accepted write owns the port next cycle
  p_write_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> (tag_en && tag_we && tag_src == 2'd3));

  // R7: collision yields a retry pulse alongside the write
  p_retry_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && snp_acc) |=> (snp_retry && tag_src == 2'd3));

  // R7: retry only ever follows a collision
  p_retry_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_retry |-> $past(wr_acc && snp_acc));

  // R8: processor displaced by a write replays right after it
  p_wr_replay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && cpu_acc) |=> ##1 (tag_src == 2'd1 && !tag_we));

  // R9: idle in, idle out
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_valid && !snp_valid && !wr_valid) |=> (!tag_en && tag_src == 2'd0));

  // R10: a stalled snoop is neither served nor retried during the replay
  p_snp_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!snp_ready && snp_valid) |=> (tag_src == 2'd1 && !snp_retry));

endmodule

bind tag_port_arb tag_port_arb_chk u_tag_port_arb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_valid (cpu_valid),
  .cpu_ready (cpu_ready),
  .snp_valid (snp_valid),
  .snp_ready (snp_ready),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .tag_en    (tag_en),
  .tag_we    (tag_we),
  .tag_src   (tag_src),
  .snp_retry (snp_retry)
);

// File: tb/tag_port_arb_bench.sv
`timescale 1ns/1ps
module tag_port_arb_bench;

  localparam int IDX_W = 7;
  localparam int TAG_W = 20;
  localparam int TID_W = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cpu_valid, snp_valid, wr_valid;
  logic             cpu_ready, snp_ready, wr_ready;
  logic [IDX_W-1:0] cpu_idx, snp_idx, wr_idx;
  logic [TID_W-1:0] cpu_tid;
  logic [TAG_W-1:0] wr_data;
  logic             tag_en, tag_we, snp_retry;
  logic [IDX_W-1:0] tag_idx;
  logic [TAG_W-1:0] tag_wdata;
  logic [1:0]       tag_src;
  logic [TID_W-1:0] tag_tid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model state
  bit               m_hold;
  logic [IDX_W-1:0] m_idx;
  logic [TID_W-1:0] m_tid;
  string            m_req;
  // expected outputs for the coming cycle
  bit               e_en, e_we, e_retry;
  logic [1:0]       e_src;
  logic [IDX_W-1:0] e_idx;
  logic [TID_W-1:0] e_tid;
  logic [TAG_W-1:0] e_wd;
  string            e_req;

  always #4 clk = ~clk;

  tag_port_arb #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TID_W(TID_W)) u_tag_port_arb (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_idx(cpu_idx), .cpu_tid(cpu_tid),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_idx(snp_idx),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
    .tag_en(tag_en), .tag_we(tag_we), .tag_idx(tag_idx), .tag_wdata(tag_wdata),
    .tag_src(tag_src), .tag_tid(tag_tid), .snp_retry(snp_retry)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Requirement-level model of one arbitration round.
  task automatic model();
    bit sv_held;
    sv_held = snp_valid;
    e_en = 0; e_we = 0; e_retry = 0; e_src = 2'd0; e_tid = '0; e_idx = 'x; e_wd = 'x;
    if (m_hold) begin
      e_en = 1; e_src = 2'd1; e_idx = m_idx; e_tid = m_tid;
      e_req = sv_held ? "R10" : m_req;
      m_hold = 0;
    end else if (wr_valid) begin
      e_en = 1; e_we = 1; e_src = 2'd3; e_idx = wr_idx; e_wd = wr_data;
      e_retry = snp_valid;
      e_req = snp_valid ? "R7" : "R6";
      if (cpu_valid) begin m_hold = 1; m_idx = cpu_idx; m_tid = cpu_tid; m_req = "R8"; end
    end else if (snp_valid) begin
      e_en = 1; e_src = 2'd2; e_idx = snp_idx; e_req = "R3";
      if (cpu_valid) begin m_hold = 1; m_idx = cpu_idx; m_tid = cpu_tid; m_req = "R4"; end
    end else if (cpu_valid) begin
      e_en = 1; e_src = 2'd1; e_idx = cpu_idx; e_tid = cpu_tid; e_req = "R2";
    end else begin
      e_req = "R9";
    end
  endtask

  // Called at a negedge; drives a request set (held stable while stalled),
  // checks readies, then checks the registered outputs one cycle later.
  task automatic cyc(input bit cv, input bit sv, input bit wv,
                     input logic [IDX_W-1:0] ci, input logic [TID_W-1:0] ct,
                     input logic [IDX_W-1:0] si, input logic [IDX_W-1:0] wi,
                     input logic [TAG_W-1:0] wd);
    bit exp_rdy;
    if (!m_hold) begin
      cpu_valid = cv; snp_valid = sv; wr_valid = wv;
      cpu_idx = ci; cpu_tid = ct; snp_idx = si; wr_idx = wi; wr_data = wd;
    end
    exp_rdy = !m_hold;
    #1;
    chk(cpu_ready == exp_rdy, "R5", "cpu_ready", cpu_ready, exp_rdy);
    chk(snp_ready == exp_rdy, "R5", "snp_ready", snp_ready, exp_rdy);
    chk(wr_ready  == exp_rdy, "R5", "wr_ready",  wr_ready,  exp_rdy);
    model();
    @(negedge clk);
    chk(tag_en == e_en,       e_req, "tag_en",    tag_en,    e_en);
    chk(tag_src == e_src,     e_req, "tag_src",   tag_src,   e_src);
    chk(tag_we == e_we,       e_req, "tag_we",    tag_we,    e_we);
    chk(snp_retry == e_retry, e_req, "snp_retry", snp_retry, e_retry);
    if (e_en) chk(tag_idx == e_idx, e_req, "tag_idx", tag_idx, e_idx);
    if (e_src == 2'd1) chk(tag_tid == e_tid, e_req, "tag_tid", tag_tid, e_tid);
    if (e_we) chk(tag_wdata == e_wd, e_req, "tag_wdata", tag_wdata, e_wd);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    m_hold = 0; m_req = "R4";
    rst_n = 1'b0;
    cpu_valid = 0; snp_valid = 0; wr_valid = 0;
    cpu_idx = '0; cpu_tid = '0; snp_idx = '0; wr_idx = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(tag_en == 0,    "R1", "tag_en",    tag_en,    0);
    chk(snp_retry == 0, "R1", "snp_retry", snp_retry, 0);
    chk(tag_src == 0,   "R1", "tag_src",   tag_src,   0);
    chk(cpu_ready && snp_ready && wr_ready, "R1", "readies",
        {cpu_ready, snp_ready, wr_ready}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tag_en == 0 && tag_src == 0 && snp_retry == 0, "R1", "after release",
        {tag_en, tag_src, snp_retry}, 0);
    chk(cpu_ready && snp_ready && wr_ready, "R1", "readies after release",
        {cpu_ready, snp_ready, wr_ready}, 3'b111);

    // Directed corners
    cyc(1, 0, 0, 7'h11, 4'h1, 7'h00, 7'h00, 20'h0);       // R2
    cyc(0, 1, 0, 7'h00, 4'h0, 7'h22, 7'h00, 20'h0);       // R3
    cyc(1, 1, 0, 7'h33, 4'h3, 7'h44, 7'h00, 20'h0);       // R4 snoop
    cyc(0, 0, 0, 7'h00, 4'h0, 7'h00, 7'h00, 20'h0);       // R4 replay, R5
    cyc(0, 0, 1, 7'h00, 4'h0, 7'h00, 7'h55, 20'hABCDE);   // R6
    cyc(0, 1, 1, 7'h00, 4'h0, 7'h66, 7'h77, 20'h12345);   // R7
    cyc(0, 0, 0, 7'h00, 4'h0, 7'h00, 7'h00, 20'h0);       // R7 pulse ends, R9
    cyc(1, 1, 1, 7'h7F, 4'h9, 7'h01, 7'h02, 20'hFFFFF);   // R7 + R8
    cyc(0, 0, 0, 7'h00, 4'h0, 7'h00, 7'h00, 20'h0);       // R8 replay
    cyc(1, 1, 0, 7'h10, 4'hA, 7'h20, 7'h00, 20'h0);       // R4
    cyc(0, 1, 0, 7'h00, 4'h0, 7'h30, 7'h00, 20'h0);       // R10 stalled (inputs held)
    cyc(0, 1, 0, 7'h00, 4'h0, 7'h30, 7'h00, 20'h0);       // R10 snoop now served
    cyc(0, 0, 0, 7'h00, 4'h0, 7'h00, 7'h00, 20'h0);       // R9

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 2) == 0, ($urandom % 3) != 0, ($urandom % 4) == 0,
          IDX_W'($urandom), TID_W'($urandom), IDX_W'($urandom),
          IDX_W'($urandom), TAG_W'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule